// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Port with Read-Modify-Write

An eight-bit general-purpose port for a small microcontroller. Each bit owns an output latch loaded from the internal data bus. A latch bit of 0 turns on the bit's pull-down and holds the pad low. A latch bit of 1 releases the pad, which then follows a pull-up or whatever an external source drives. The resolved pad level comes back into the block as an input.

Two read paths share one read bus. The pin path returns the pad level after a two-flop synchronizer. The latch path returns the stored latch value directly. A bit can serve as an input only while its latch holds 1, so software writes ones to a port before reading it as an input.

Read-modify-write operations always take the latch value, never the pad. They apply a logical, arithmetic or single-bit operation and load the result back into the latch. The new value then drives the pad. A parameter chooses between an internal pull-up and an open-drain output.

Top module: `qbd_port`

## Requirements
- R1: On a clock edge with `wr_en` high and `rmw_en` low, the latch loads `wr_data`. With both strobes low, the latch keeps its value.
- R2: `pd_en` is the bitwise inverse of the latch. When `PULLUP` is 1, `pu_en` equals the latch; when `PULLUP` is 0, `pu_en` is all zeros.
- R3: With `rd_pin_en` high, `rd_data` shows `pad_in` as it was sampled two rising edges earlier, through two flops.
- R4: With `rd_latch_en` high and `rd_pin_en` low, `rd_data` equals the current latch value. With neither strobe high, `rd_data` is 0. If both are high, the pin path wins.
- R5: A bit whose latch holds 0 reads 0 on the pin path even while an external source drives it high, because its pull-down dominates the pad.
- R6: With `rmw_en` high, op code 0 loads latch AND `rmw_arg`, code 1 loads latch OR `rmw_arg`, and code 2 loads latch XOR `rmw_arg`. All three take the latch value, never the pad.
- R7: Op code 3 loads latch+1 and op code 4 loads latch-1, both modulo 2^W (0xFF+1 gives 0x00, 0x00-1 gives 0xFF).
- R8: Op codes 5 (set), 6 (clear), 7 (complement) and 8 (load `carry_in`) act on bit `rmw_bit` only. Every other latch bit is left unchanged.
- R9: `rmw_en` takes priority over `wr_en` in the same cycle. Op codes 9 to 15 leave the latch unchanged.
- R10: While `rst_n` is low, the latch is 0xFF and both synchronizer stages are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the latch |
| wr_data | input | W | Value to write into the latch |
| rmw_en | input | 1 | Read-modify-write strobe |
| rmw_op | input | 4 | Read-modify-write op code |
| rmw_arg | input | W | Operand for AND/OR/XOR |
| rmw_bit | input | $clog2(W) | Bit index for the single-bit ops |
| carry_in | input | 1 | Carry value for op code 8 |
| rd_pin_en | input | 1 | Select the synchronized pad level onto the read bus |
| rd_latch_en | input | 1 | Select the latch onto the read bus |
| rd_data | output | W | Read data bus |
| pad_in | input | W | Resolved pad level |
| pd_en | output | W | Pull-down enable per bit |
| pu_en | output | W | Internal pull-up enable per bit |

## Verification
The bench builds two copies with W=8: `u0` with `PULLUP=0` (open drain) and `u1` with `PULLUP=1`. This brings both pull-up variants within reach of R2 in one run. The bench's pad model supplies the external pull-up that the open-drain copy needs and an external driver for each bit. Mixing random external drive with random latch contents exercises the case of a pad forced low while the external source drives high. It also exercises the case of a pad driven low externally while a latch operation reads back the stored ones.

// File: rtl/qbd_port.sv
module qbd_port #(
  parameter int W      = 8,
  parameter bit PULLUP = 1'b1,
  localparam int BW    = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rmw_en,
  input  logic [3:0]    rmw_op,
  input  logic [W-1:0]  rmw_arg,
  input  logic [BW-1:0] rmw_bit,
  input  logic          carry_in,
  input  logic          rd_pin_en,
  input  logic          rd_latch_en,
  output logic [W-1:0]  rd_data,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pd_en,
  output logic [W-1:0]  pu_en
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] lat, nxt, s1, s2;

  always_comb begin
    nxt = lat;
    case (rmw_op)
      4'd0: nxt = lat & rmw_arg;
      4'd1: nxt = lat | rmw_arg;
      4'd2: nxt = lat ^ rmw_arg;
      4'd3: nxt = lat + ONE;
      4'd4: nxt = lat - ONE;
      4'd5: nxt[rmw_bit] = 1'b1;
      4'd6: nxt[rmw_bit] = 1'b0;
      4'd7: nxt[rmw_bit] = ~lat[rmw_bit];
      4'd8: nxt[rmw_bit] = carry_in;
      default: nxt = lat;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat <= '1;
    else if (rmw_en) lat <= nxt;
    else if (wr_en)  lat <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
    end else begin
      s1 <= pad_in;
      s2 <= s1;
    end
  end

  assign rd_data = rd_pin_en ? s2 : (rd_latch_en ? lat : '0);
  assign pd_en   = ~lat;

  generate
    if (PULLUP) begin : g_pu
      assign pu_en = lat;
    end else begin : g_od
      assign pu_en = '0;
    end
  endgenerate

endmodule

// File: rtl/qbd_port_chk.sv
module qbd_port_chk #(
  parameter int W      = 8,
  parameter bit PULLUP = 1'b1,
  localparam int BW    = (W > 1) ? $clog2(W) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [W-1:0]  wr_data,
  input logic          rmw_en,
  input logic [3:0]    rmw_op,
  input logic [BW-1:0] rmw_bit,
  input logic          rd_pin_en,
  input logic          rd_latch_en,
  input logic [W-1:0]  rd_data,
  input logic [W-1:0]  pd_en,
  input logic [W-1:0]  pu_en
);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rmw_en) |=> $stable(pd_en));

  assert_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rmw_en) |=> (pd_en == ~$past(wr_data)));

  assert_pullup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    PULLUP ? (pu_en == ~pd_en) : (pu_en == '0));

  assert_idle_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_pin_en && !rd_latch_en) |-> (rd_data == '0));

  assert_latch_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_latch_en && !rd_pin_en) |-> (rd_data == ~pd_en));

  assert_bit_isolation_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_en && rmw_op >= 4'd5 && rmw_op <= 4'd8) |=>
      (((pd_en ^ $past(pd_en)) & ~(W'(1) << $past(rmw_bit))) == '0));

  assert_unused_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_en && rmw_op >= 4'd9) |=> $stable(pd_en));

endmodule

bind qbd_port qbd_port_chk #(.W(W), .PULLUP(PULLUP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_bit(rmw_bit),
  .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en), .rd_data(rd_data),
  .pd_en(pd_en), .pu_en(pu_en)
);

// File: tb/sim_qbd_port.sv
`timescale 1ns/1ps
module sim_qbd_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rmw_en = 0, carry_in = 0, rd_pin_en = 0, rd_latch_en = 0;
  logic [7:0] wr_data = 0, rmw_arg = 0, ext_oe = 0, ext_val = 0;
  logic [3:0] rmw_op = 0;
  logic [2:0] rmw_bit = 0;
  logic [7:0] rd0, rd1, pd0, pd1, pu0, pu1, pad0, pad1;
  logic [7:0] m = 8'hFF;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] f_pad(input logic [7:0] pd, input logic [7:0] oe, input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = pd[i] ? 1'b0 : (oe[i] ? v[i] : 1'b1);
    return r;
  endfunction

  function automatic logic [7:0] f_rmw(input logic [7:0] l, input logic [3:0] op,
                                       input logic [7:0] a, input logic [2:0] b, input logic c);
    logic [7:0] r;
    r = l;
    case (op)
      4'd0: r = l & a;
      4'd1: r = l | a;
      4'd2: r = l ^ a;
      4'd3: r = l + 8'd1;
      4'd4: r = l - 8'd1;
      4'd5: r[b] = 1'b1;
      4'd6: r[b] = 1'b0;
      4'd7: r[b] = ~l[b];
      4'd8: r[b] = c;
      default: r = l;
    endcase
    return r;
  endfunction

  function automatic string f_tag(input bit r, input logic [3:0] op);
    if (!r) return "R1";
    if (op <= 4'd2) return "R6";
    if (op <= 4'd4) return "R7";
    if (op <= 4'd8) return "R8";
    return "R9";
  endfunction

  assign pad0 = f_pad(pd0, ext_oe, ext_val);
  assign pad1 = f_pad(pd1, ext_oe, ext_val);

  qbd_port #(.W(8), .PULLUP(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rmw_en(rmw_en),
    .rmw_op(rmw_op), .rmw_arg(rmw_arg), .rmw_bit(rmw_bit), .carry_in(carry_in),
    .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en), .rd_data(rd0),
    .pad_in(pad0), .pd_en(pd0), .pu_en(pu0));

  qbd_port #(.W(8), .PULLUP(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rmw_en(rmw_en),
    .rmw_op(rmw_op), .rmw_arg(rmw_arg), .rmw_bit(rmw_bit), .carry_in(carry_in),
    .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en), .rd_data(rd1),
    .pad_in(pad1), .pd_en(pd1), .pu_en(pu1));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic step(input bit w, input logic [7:0] wd, input bit r, input logic [3:0] op,
                      input logic [7:0] a, input logic [2:0] b, input logic c,
                      input logic [7:0] oe, input logic [7:0] ev);
    string t;
    t = f_tag(r, op);
    @(negedge clk);
    wr_en = w; wr_data = wd; rmw_en = r; rmw_op = op; rmw_arg = a;
    rmw_bit = b; carry_in = c; ext_oe = oe; ext_val = ev;
    @(posedge clk);
    if (r) m = f_rmw(m, op, a, b, c);
    else if (w) m = wd;
    @(negedge clk);
    wr_en = 0; rmw_en = 0;
    rd_latch_en = 1;
    #1;
    chk({t, " latch read u0"}, rd0, m);
    chk({t, " latch read u1"}, rd1, m);
    rd_latch_en = 0;
    #1;
    chk("R4 idle bus", rd0, 8'h00);
    chk("R2 pd_en", pd0, ~m);
    chk("R2 pu_en open drain", pu0, 8'h00);
    chk("R2 pu_en pull-up", pu1, m);
    @(negedge clk);
    @(negedge clk);
    rd_pin_en = 1;
    #1;
    chk("R3 R5 pin read", rd0, f_pad(~m, oe, ev));
    rd_pin_en = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_latch_en = 1; #1 chk("R10 reset latch", rd0, 8'hFF);
    rd_latch_en = 0; rd_pin_en = 1; #1 chk("R10 reset pin path", rd0, 8'hFF);
    rd_pin_en = 0; #1 chk("R10 reset pd_en", pd0, 8'h00);
    rst_n = 1;

    step(1, 8'h55, 0, 0, 0, 0, 0, 8'h00, 8'h00);
    step(0, 8'h00, 0, 0, 0, 0, 0, 8'hFF, 8'hFF);
    step(1, 8'hFF, 0, 0, 0, 0, 0, 8'hFF, 8'h00);
    step(0, 8'h00, 1, 4'd1, 8'h00, 0, 0, 8'hFF, 8'h00);
    step(0, 8'h00, 1, 4'd3, 8'h00, 0, 0, 8'h00, 8'h00);
    step(0, 8'h00, 1, 4'd4, 8'h00, 0, 0, 8'h00, 8'h00);
    step(0, 8'h00, 1, 4'd2, 8'hFF, 0, 0, 8'h00, 8'h00);
    step(1, 8'h00, 1, 4'd0, 8'hF0, 0, 0, 8'h00, 8'h00);
    step(1, 8'h12, 1, 4'd12, 8'h00, 0, 0, 8'h00, 8'h00);
    step(0, 8'h00, 1, 4'd8, 8'h00, 3'd7, 1'b1, 8'h00, 8'h00);

    @(negedge clk);
    rd_pin_en = 1; rd_latch_en = 1;
    ext_oe = 8'hFF; ext_val = 8'h0F;
    @(negedge clk); @(negedge clk); @(negedge clk);
    #1 chk("R4 pin wins over latch", rd0, f_pad(~m, 8'hFF, 8'h0F));
    rd_pin_en = 0; rd_latch_en = 0;

    for (int i = 0; i < 400; i++) begin
      logic [2:0] sel;
      sel = 3'($urandom_range(0, 7));
      step(sel <= 3'd2, 8'($urandom), sel >= 3'd3, 4'($urandom_range(0, 15)),
           8'($urandom), 3'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule